// File: doc/BRIEF.md
# Serial Fuse-Word Program Sequencer

This block writes one 32-bit word into a one-time-programmable fuse array. A start request in the idle state captures the word address, the data to burn and a packed timing word. The sequencer then senses the current contents of that fuse word with a timed read strobe. It clears from the request every bit that is already blown. The remaining data is walked out least-significant bit first, one fuse bit per slot. Each slot drives the program strobe only when its bit is 1.

Every slot takes the same number of cycles whether or not its bit is burned, so the run time of a word depends only on the timing word and a recovery-gap parameter. Busy stays high through a fixed post-write recovery interval, which keeps the array quiet for the required settling time (2 us at the default 400-cycle gap and 200 MHz). Busy then drops, and a one-cycle done pulse returns the sequencer to idle. It is driven by a register file that owns the software-visible control and data registers.

Top module: `fuse_prog_engine`

## Requirements
- R1: After reset, busy_o, done_o, fuse_rd_strobe_o and fuse_pgm_strobe_o are all 0.
- R2: start_i is taken only in idle. It captures addr_i, wdata_i and timing_i, and fuse_addr_o holds the captured address for the whole operation. Later changes on those inputs have no effect on the operation.
- R3: Each operation begins with fuse_rd_strobe_o high for N cycles, where N is timing_i[21:16] and a value of 0 counts as 1. fuse_rdata_i is sampled in the last of those cycles.
- R4: Only bits that are 1 in the captured data and 0 in the sensed word get a program pulse. The final fuse word equals the old word OR the data, and no already-blown bit is ever pulsed.
- R5: Bits are visited in ascending order 0 to 31. fuse_bit_o gives the index of the bit in its slot, and the working data shifts right with zero fill after each slot.
- R6: Each program pulse is P cycles wide, where P is timing_i[11:0] and a value of 0 counts as 1. fuse_bit_o is stable during the pulse.
- R7: Each bit slot has R = timing_i[15:12] + 1 quiet cycles before and after the strobe window, so a zero relax field still gives one quiet cycle on each side. Every slot lasts 2R+P cycles whether or not its bit is burned.
- R8: After the last slot, busy_o stays high for GAP_CYCLES more cycles. busy_o is therefore high for exactly N + 32*(2R+P) + GAP_CYCLES cycles per operation.
- R9: done_o is a single-cycle pulse in the cycle right after busy_o falls, with busy_o low during it. The sequencer is idle and ready for a new start in the next cycle.
- R10: A start_i pulse while busy is ignored. It causes no extra operation and no write to the address it carries.
- R11: The read and program strobes are never high together, and the program strobe is high only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| addr_i | input | AW | Fuse word address |
| wdata_i | input | DW | Data to program; 1 = blow bit |
| timing_i | input | 32 | [11:0] program width, [15:12] relax, [21:16] read width |
| fuse_rdata_i | input | DW | Sensed fuse word from the array |
| fuse_addr_o | output | AW | Word address to the array |
| fuse_rd_strobe_o | output | 1 | Array read strobe |
| fuse_pgm_strobe_o | output | 1 | Array program strobe |
| fuse_bit_o | output | $clog2(DW) | Bit index being programmed |
| busy_o | output | 1 | Operation in progress, including recovery gap |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The in-line properties check, on every cycle, the parts of the behaviour that need no memory of the fuse contents. These are exclusive strobes and strobes only while busy, the held address, a bit index that does not move during a pulse, zero fill and a one-step index advance on each shift, and the single-cycle done pulse after busy falls. The masking against the pre-read, the final fuse contents, the pulse widths, the per-slot and total cycle counts, and the rejection of a start while busy all depend on a fuse model and on timing-word settings. Only the bench's scenarios show those, by running several data/pre-content/timing combinations through a behavioural fuse array.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_PRE,
        ST_STRB,
        ST_POST,
        ST_GAP,
        ST_DONE
    } fpe_state_e;

    // field positions inside the packed timing word (decoded by the register file too)
    localparam int PROG_LSB  = 0;
    localparam int PROG_W    = 12;
    localparam int RELAX_LSB = 12;
    localparam int RELAX_W   = 4;
    localparam int RD_LSB    = 16;
    localparam int RD_W      = 6;
    localparam int TIM_W     = 32;
endpackage

// File: rtl/fpe_timing_decode.sv
module fpe_timing_decode
    import fpe_pkg::*;
#(
    parameter int CW = 13
) (
    input  logic [TIM_W-1:0] timing_i,
    output logic [CW-1:0]    rd_len_m1_o,
    output logic [CW-1:0]    relax_len_m1_o,
    output logic [CW-1:0]    prog_len_m1_o
);
    logic [PROG_W-1:0]  prog_f;
    logic [RELAX_W-1:0] relax_f;
    logic [RD_W-1:0]    rd_f;
    logic               unused_hi;

    assign prog_f    = timing_i[PROG_LSB +: PROG_W];
    assign relax_f   = timing_i[RELAX_LSB +: RELAX_W];
    assign rd_f      = timing_i[RD_LSB +: RD_W];
    assign unused_hi = ^timing_i[TIM_W-1:RD_LSB+RD_W];

    always_comb begin
        // a zero width is stretched to one cycle
        rd_len_m1_o    = (rd_f == '0)   ? '0 : CW'(rd_f) - CW'(1);
        prog_len_m1_o  = (prog_f == '0) ? '0 : CW'(prog_f) - CW'(1);
        // relax field value v gives v+1 quiet cycles
        relax_len_m1_o = CW'(relax_f);
    end
endmodule

// File: rtl/fpe_interval_counter.sv
module fpe_interval_counter #(
    parameter int CW = 13
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.cnt = load_val_i;
        end else if (cnt_q.cnt != '0) begin
            cnt_d.cnt = cnt_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q.cnt == '0);

    AST_CNT_HOLDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (zero_o && !load_i) |=> zero_o); // R8
    AST_CNT_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (zero_o == ($past(load_val_i) == '0))); // R7
endmodule

// File: rtl/fpe_bit_shifter.sv
module fpe_bit_shifter #(
    parameter int DW = 32,
    localparam int IW = $clog2(DW)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    input  logic          shift_i,
    output logic          lsb_o,
    output logic [IW-1:0] idx_o,
    output logic          last_o
);
    typedef struct packed {
        logic [DW-1:0] sreg;
        logic [IW-1:0] idx;
    } sh_state_t;

    sh_state_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.sreg = load_val_i;
            sh_d.idx  = '0;
        end else if (shift_i) begin
            sh_d.sreg = {1'b0, sh_q.sreg[DW-1:1]};
            sh_d.idx  = sh_q.idx + IW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign lsb_o  = sh_q.sreg[0];
    assign idx_o  = sh_q.idx;
    assign last_o = (sh_q.idx == IW'(DW - 1));

    AST_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && !load_i) |=> (sh_q.sreg[DW-1] == 1'b0)); // R5
    AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && !load_i) |=> (idx_o == $past(idx_o) + IW'(1))); // R5
endmodule

// File: rtl/fuse_prog_engine.sv
module fuse_prog_engine
    import fpe_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 32,
    parameter int GAP_CYCLES = 400,
    localparam int IW        = $clog2(DW)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [TIM_W-1:0]  timing_i,
    input  logic [DW-1:0]     fuse_rdata_i,
    output logic [AW-1:0]     fuse_addr_o,
    output logic              fuse_rd_strobe_o,
    output logic              fuse_pgm_strobe_o,
    output logic [IW-1:0]     fuse_bit_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam int CW = (GW > PROG_W) ? GW + 1 : PROG_W + 1;
    localparam logic [CW-1:0] GAP_M1 = CW'(GAP_CYCLES - 1);

    typedef struct packed {
        fpe_state_e        state;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     data;
        logic [TIM_W-1:0]  timing;
    } eng_state_t;

    eng_state_t eng_d, eng_q;

    logic [TIM_W-1:0] dec_in;
    logic [CW-1:0]    rd_m1, relax_m1, prog_m1;
    logic             cnt_load, cnt_zero;
    logic [CW-1:0]    cnt_val;
    logic             sh_load, sh_shift, sh_lsb, sh_last;
    logic [DW-1:0]    sh_val;
    logic [IW-1:0]    sh_idx;

    // in idle the live timing word is decoded so the read interval loads on start
    assign dec_in = (eng_q.state == ST_IDLE) ? timing_i : eng_q.timing;

    fpe_timing_decode #(.CW(CW)) u_dec (
        .timing_i      (dec_in),
        .rd_len_m1_o   (rd_m1),
        .relax_len_m1_o(relax_m1),
        .prog_len_m1_o (prog_m1)
    );

    fpe_interval_counter #(.CW(CW)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (cnt_load),
        .load_val_i(cnt_val),
        .zero_o    (cnt_zero)
    );

    fpe_bit_shifter #(.DW(DW)) u_sh (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (sh_load),
        .load_val_i(sh_val),
        .shift_i   (sh_shift),
        .lsb_o     (sh_lsb),
        .idx_o     (sh_idx),
        .last_o    (sh_last)
    );

    always_comb begin
        eng_d    = eng_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_val   = eng_q.data & ~fuse_rdata_i;
        unique case (eng_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    eng_d.state  = ST_READ;
                    eng_d.addr   = addr_i;
                    eng_d.data   = wdata_i;
                    eng_d.timing = timing_i;
                    cnt_load     = 1'b1;
                    cnt_val      = rd_m1;
                end
            end
            ST_READ: begin
                if (cnt_zero) begin
                    sh_load     = 1'b1;
                    eng_d.state = ST_PRE;
                    cnt_load    = 1'b1;
                    cnt_val     = relax_m1;
                end
            end
            ST_PRE: begin
                if (cnt_zero) begin
                    eng_d.state = ST_STRB;
                    cnt_load    = 1'b1;
                    cnt_val     = prog_m1;
                end
            end
            ST_STRB: begin
                if (cnt_zero) begin
                    eng_d.state = ST_POST;
                    cnt_load    = 1'b1;
                    cnt_val     = relax_m1;
                end
            end
            ST_POST: begin
                if (cnt_zero) begin
                    cnt_load = 1'b1;
                    if (sh_last) begin
                        eng_d.state = ST_GAP;
                        cnt_val     = GAP_M1;
                    end else begin
                        sh_shift    = 1'b1;
                        eng_d.state = ST_PRE;
                        cnt_val     = relax_m1;
                    end
                end
            end
            ST_GAP: begin
                if (cnt_zero) begin
                    eng_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                eng_d.state = ST_IDLE;
            end
            default: begin
                eng_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q       <= '0;
            eng_q.state <= ST_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign fuse_addr_o       = eng_q.addr;
    assign fuse_rd_strobe_o  = (eng_q.state == ST_READ);
    assign fuse_pgm_strobe_o = (eng_q.state == ST_STRB) && sh_lsb;
    assign fuse_bit_o        = sh_idx;
    assign busy_o            = (eng_q.state != ST_IDLE) && (eng_q.state != ST_DONE);
    assign done_o            = (eng_q.state == ST_DONE);

    AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(fuse_rd_strobe_o && fuse_pgm_strobe_o)); // R11
    AST_PGM_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fuse_pgm_strobe_o |-> busy_o); // R11
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o))); // R9
    AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> $stable(fuse_addr_o)); // R2
    AST_BIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fuse_pgm_strobe_o && $past(fuse_pgm_strobe_o)) |-> $stable(fuse_bit_o)); // R6
endmodule

// File: tb/fuse_prog_engine_tb.sv
module fuse_prog_engine_tb_top;
    localparam int AW  = 8;
    localparam int DW  = 32;
    localparam int GAP = 400;
    localparam int NV  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [31:0]   timing = '0;
    logic [DW-1:0] frd;
    logic [AW-1:0] faddr;
    logic          rd_stb, pgm_stb, busy, done;
    logic [4:0]    fbit;

    always #2.5 clk = ~clk; // 200 MHz

    fuse_prog_engine #(.AW(AW), .DW(DW), .GAP_CYCLES(GAP)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
        .wdata_i(wdata), .timing_i(timing), .fuse_rdata_i(frd),
        .fuse_addr_o(faddr), .fuse_rd_strobe_o(rd_stb),
        .fuse_pgm_strobe_o(pgm_stb), .fuse_bit_o(fbit),
        .busy_o(busy), .done_o(done)
    );

    // behavioural fuse array and monitors
    logic [DW-1:0] fmem [16];
    logic          pl_en = 1'b0;
    logic [3:0]    pl_addr = '0;
    logic [DW-1:0] pl_val = '0;
    int            exp_p = 1;
    int unsigned   busy_cnt = 0, rd_cnt = 0, pulses = 0, reblow = 0;
    int unsigned   order_err = 0, width_err = 0, strobe_err = 0, run_len = 0;
    int            last_bit = -1;
    logic          prev_pgm = 1'b0;

    assign frd = fmem[faddr[3:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) fmem[i] <= '0;
            prev_pgm <= 1'b0;
        end else begin
            if (pl_en) fmem[pl_addr] <= pl_val;
            else if (pgm_stb) fmem[faddr[3:0]][fbit] <= 1'b1;
            busy_cnt <= busy_cnt + int'(busy);
            rd_cnt   <= rd_cnt + int'(rd_stb);
            if ((rd_stb && pgm_stb) || (pgm_stb && !busy)) strobe_err <= strobe_err + 1;
            if (rd_stb) last_bit <= -1;
            if (pgm_stb && !prev_pgm) begin
                pulses <= pulses + 1;
                if (fmem[faddr[3:0]][fbit]) reblow <= reblow + 1;
                if (int'(fbit) <= last_bit) order_err <= order_err + 1;
                last_bit <= int'(fbit);
                run_len  <= 1;
            end else if (pgm_stb) begin
                run_len <= run_len + 1;
            end
            if (!pgm_stb && prev_pgm && run_len != exp_p) width_err <= width_err + 1;
            prev_pgm <= pgm_stb;
        end
    end

    int n_cmp = 0, n_bad = 0;
    int unsigned cyc = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
            $finish;
        end
    end

    function automatic logic [31:0] tim(input int p, input int r, input int rd);
        return {10'h0, 6'(rd), 4'(r), 12'(p)};
    endfunction

    function automatic int popc(input logic [31:0] v);
        int c = 0;
        for (int i = 0; i < 32; i++) c += int'(v[i]);
        return c;
    endfunction

    // vectors: address, previous fuse content, request data, timing word
    localparam logic [3:0]  V_ADDR [NV] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd7};
    localparam logic [31:0] V_PRE  [NV] = '{32'h0, 32'hFFFF_0000, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_00F0};
    localparam logic [31:0] V_DATA [NV] = '{32'hA5A5_0F0F, 32'h1234_FFFF, 32'h0, 32'hFFFF_FFFF,
                                            32'h8000_0001, 32'hFFFF_FFFF};
    localparam int V_P  [NV] = '{3, 5, 2, 2, 0, 7};
    localparam int V_R  [NV] = '{0, 2, 1, 1, 3, 1};
    localparam int V_RD [NV] = '{2, 0, 4, 1, 63, 1};

    task automatic run_op(input logic [3:0] a, input logic [31:0] pre, input logic [31:0] d,
                          input int p, input int r, input int rd, input bit inject);
        int unsigned b0, r0, pu0, rb0, ow0, wd0, se0;
        int pe, re, rde, k;
        pe  = (p == 0) ? 1 : p;
        re  = r + 1;
        rde = (rd == 0) ? 1 : rd;
        @(negedge clk);
        pl_en = 1'b1; pl_addr = a; pl_val = pre;
        @(negedge clk);
        pl_en = 1'b0;
        exp_p = pe;
        b0 = busy_cnt; r0 = rd_cnt; pu0 = pulses; rb0 = reblow;
        ow0 = order_err; wd0 = width_err; se0 = strobe_err;
        start = 1'b1; addr = {4'h0, a}; wdata = d; timing = tim(p, r, rd);
        @(negedge clk);
        start = 1'b0; addr = 8'h0F; wdata = 32'hFFFF_FFFF; timing = 32'h0; // R2 later input changes
        if (inject) begin
            repeat (20) @(negedge clk);
            start = 1'b1; addr = 8'h05; wdata = 32'hFFFF_FFFF; timing = tim(1, 0, 1);
            @(negedge clk);
            start = 1'b0;
        end
        k = 0;
        while (!done && k < 30000) begin
            @(negedge clk);
            k++;
        end
        chk("R9 done pulse seen", 32'(done), 32'd1);
        chk("R9 busy low with done", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R9 done lasts one cycle", 32'(done), 32'd0);
        chk("R4 final fuse word", fmem[a], pre | d);
        chk("R4 pulse count", pulses - pu0, 32'(popc(d & ~pre)));
        chk("R4 no reblow", reblow - rb0, 32'd0);
        chk("R5 ascending bit order", order_err - ow0, 32'd0);
        chk("R6 pulse width", width_err - wd0, 32'd0);
        chk("R3 read strobe cycles", rd_cnt - r0, 32'(rde));
        chk("R7 R8 busy cycles", busy_cnt - b0, 32'(rde + 32 * (2 * re + pe) + GAP));
        chk("R11 strobe rules", strobe_err - se0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 strobes after reset", {30'h0, rd_stb, pgm_stb}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 32'(busy), 32'd0);

        for (int v = 0; v < NV; v++) begin
            run_op(V_ADDR[v], V_PRE[v], V_DATA[v], V_P[v], V_R[v], V_RD[v], 1'b0);
        end

        // R10: start while busy ignored; address 5 must remain blank
        run_op(4'd8, 32'h0, 32'h0F0F_0001, 2, 0, 1, 1'b1);
        repeat (5) @(negedge clk);
        chk("R10 no extra operation", 32'(busy), 32'd0);
        chk("R10 target of ignored start untouched", fmem[5], 32'h0);

        // R9: back-to-back operation right after done
        run_op(4'd9, 32'h0000_0002, 32'h0000_0003, 1, 0, 1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule